// File: doc/BRIEF.md
# Floppy Head Seek Sequencer

This block moves a floppy drive head to a requested track. The host first writes the target track into a target register. It then writes a command byte. The block compares the target with its track register, which holds the current head position. It sets a direction line and then issues single-cycle step pulses. Each pulse is spaced by a number of 1 kHz ticks, and that number comes from the command's rate field. The track register moves one position per pulse. Stepping stops when the track register equals the target.

When the command asks for verification, the block then watches a decoded-ID input. Each ID carries a track number and a CRC-good flag. A good ID whose track matches ends the command cleanly. An ID with a bad CRC ends it with a CRC error. Five index pulses with no match end it with a seek error. A busy bit tracks the command. An interrupt line rises at the moment busy drops, and reading the status register clears that line. An abort command is accepted at any time: it stops the command and raises the interrupt.

Register map (2-bit `addr`): 0 = command on write, status on read; 1 = track register; 2 = target register; 3 reads as zero. Command byte: bits 7:4 are the opcode (4'h1 = seek, 4'hD = abort; any other opcode is ignored), bit 2 enables verify, bits 1:0 select the rate, and bit 3 is unused. Status byte: bit 0 = busy, bit 3 = CRC error, bit 4 = seek error, and all other bits are zero.

Top module: `seek_sequencer`

## Requirements
- R1: The rate field sets the spacing between consecutive step pulses to 6, 12, 20 or 30 ticks of `tick_1k`, for codes 00, 01, 10 and 11.
- R2: A seek issues exactly |target − track| step pulses, and the track register changes by one on each pulse. When the two are already equal, no pulse is issued.
- R3: `step_dir_o` is 1 when the target is above the track and 0 when it is below. It is set when the command is accepted, which is before the first pulse, and it does not change while the command runs.
- R4: Each step pulse on `step_o` is exactly one clock cycle wide.
- R5: With verify enabled, an ID that has a good CRC but a different track is ignored. An ID that has a good CRC and matches the track register ends the command with status 8'h00.
- R6: During verify, an ID with a bad CRC ends the command with status bit 3 set (status 8'h08).
- R7: During verify, the fifth index pulse without a matching ID ends the command with status bit 4 set (status 8'h10). After only four index pulses the block is still busy.
- R8: Status bit 0 is 1 from the clock edge that accepts a command until it completes. It drops on the same edge that raises `irq_o`.
- R9: `irq_o` stays high until the status register is read (`rd_en` with `addr` 0). It is low on the cycle after that read.
- R10: A command write while busy is ignored, unless its opcode is 4'hD. The 4'hD command stops stepping at once, clears busy and raises `irq_o`.
- R11: Writes to the track and target registers take effect only while the block is idle, and both registers read back what was written.
- R12: After reset, status, track, target, `irq_o` and `step_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | One-cycle pulse at 1 kHz, used for step timing |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe (status read clears the interrupt) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the selected register |
| index_pulse | input | 1 | One-cycle pulse per disk revolution |
| id_valid | input | 1 | Decoded ID field present this cycle |
| id_track | input | 8 | Track number from the decoded ID |
| id_crc_ok | input | 1 | CRC of the decoded ID was good |
| step_o | output | 1 | Step pulse to the drive |
| step_dir_o | output | 1 | Step direction, 1 = toward higher tracks |
| irq_o | output | 1 | Interrupt request |

## Verification
Seeks are run upward and downward at each of the four rates. The set includes a one-track move, a zero-length move and a 200-track move. Together these separate a wrong pulse count, a wrong tick spacing, an inverted direction and a failure to finish when no movement is needed.

The verify phase is tried with three inputs: a non-matching good ID followed by a matching one, a bad-CRC ID, and a run of bare index pulses. These show that each outcome sets its own status bit. Writes made while busy, together with a mid-seek abort, show that only the abort opcode changes what the block does.

// File: rtl/seek_seq_pkg.sv
package seek_seq_pkg;

    localparam int TRK_W  = 8;
    localparam int TICK_W = 8;

    localparam logic [1:0] ADDR_CMD    = 2'd0;
    localparam logic [1:0] ADDR_TRACK  = 2'd1;
    localparam logic [1:0] ADDR_TARGET = 2'd2;

    localparam logic [3:0] OP_SEEK  = 4'h1;
    localparam logic [3:0] OP_ABORT = 4'hD;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STEP,
        SQ_VERIFY
    } seq_state_e;

    typedef struct packed {
        logic [3:0] op;
        logic       spare;
        logic       verify;
        logic [1:0] rate;
    } cmd_t;

    typedef struct packed {
        logic busy;
        logic crc_err;
        logic seek_err;
    } stat_t;

    // Number of 1 kHz ticks between step pulses for each rate code
    function automatic logic [TICK_W-1:0] rate_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return TICK_W'(6);
            2'd1:    return TICK_W'(12);
            2'd2:    return TICK_W'(20);
            default: return TICK_W'(30);
        endcase
    endfunction

    function automatic logic [7:0] pack_status(input stat_t s);
        return {3'b000, s.seek_err, s.crc_err, 2'b00, s.busy};
    endfunction

endpackage

// File: rtl/seek_step_timer.sv
module seek_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic             due
);
    logic [CNT_W-1:0] cnt_q;

    // Fires on the tick that completes one full interval
    assign due = run && tick && (cnt_q == interval - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (due) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seek_id_verify.sv
module seek_id_verify #(
    parameter int TRK_W     = 8,
    parameter int IDX_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             index_pulse,
    input  logic             id_valid,
    input  logic [TRK_W-1:0] id_track,
    input  logic             id_crc_ok,
    input  logic [TRK_W-1:0] cur_track,
    output logic             pass,
    output logic             crc_fail,
    output logic             timeout
);
    localparam int IW = $clog2(IDX_LIMIT + 1);

    logic [IW-1:0] idx_q;

    assign pass     = active && id_valid && id_crc_ok && (id_track == cur_track);
    assign crc_fail = active && id_valid && !id_crc_ok;
    assign timeout  = active && !pass && !crc_fail && index_pulse
                      && (idx_q == IW'(IDX_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            idx_q <= '0;
        end else if (index_pulse) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/seek_sequencer.sv
module seek_sequencer
    import seek_seq_pkg::*;
#(
    parameter int IDX_LIMIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1k,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       index_pulse,
    input  logic       id_valid,
    input  logic [7:0] id_track,
    input  logic       id_crc_ok,
    output logic       step_o,
    output logic       step_dir_o,
    output logic       irq_o
);
    seq_state_e       state_q;
    logic [TRK_W-1:0] track_q;
    logic [TRK_W-1:0] target_q;
    logic             verify_q;
    logic [1:0]       rate_q;
    logic             dir_q;
    stat_t            stat_q;
    logic             irq_q;
    logic             step_q;

    cmd_t cmd_in;
    logic unused_spare;
    logic cmd_wr, abort_req, seek_req, stat_rd, busy_q;
    logic at_target, stepping, step_due;
    logic vf_pass, vf_crc, vf_timeout, vf_active;

    assign cmd_in       = cmd_t'(wdata);
    assign unused_spare = cmd_in.spare;
    assign busy_q       = stat_q.busy;

    assign cmd_wr    = wr_en && (addr == ADDR_CMD);
    assign abort_req = cmd_wr && (cmd_in.op == OP_ABORT);
    assign seek_req  = cmd_wr && (cmd_in.op == OP_SEEK) && (state_q == SQ_IDLE);
    assign stat_rd   = rd_en && (addr == ADDR_CMD);
    assign at_target = (track_q == target_q);
    assign stepping  = (state_q == SQ_STEP) && !at_target;
    assign vf_active = (state_q == SQ_VERIFY);

    seek_step_timer #(.CNT_W(TICK_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (seek_req),
        .run      (stepping),
        .tick     (tick_1k),
        .interval (rate_ticks(rate_q)),
        .due      (step_due)
    );

    seek_id_verify #(.TRK_W(TRK_W), .IDX_LIMIT(IDX_LIMIT)) u_verify (
        .clk         (clk),
        .rst         (rst),
        .active      (vf_active),
        .index_pulse (index_pulse),
        .id_valid    (id_valid),
        .id_track    (id_track),
        .id_crc_ok   (id_crc_ok),
        .cur_track   (track_q),
        .pass        (vf_pass),
        .crc_fail    (vf_crc),
        .timeout     (vf_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            track_q  <= '0;
            target_q <= '0;
            verify_q <= 1'b0;
            rate_q   <= 2'd0;
            dir_q    <= 1'b0;
            stat_q   <= '0;
            irq_q    <= 1'b0;
            step_q   <= 1'b0;
        end else begin
            step_q <= 1'b0;
            if (stat_rd) irq_q <= 1'b0;
            if (abort_req) begin
                state_q     <= SQ_IDLE;
                stat_q.busy <= 1'b0;
                irq_q       <= 1'b1;
            end else begin
                case (state_q)
                    SQ_IDLE: begin
                        if (seek_req) begin
                            state_q         <= SQ_STEP;
                            stat_q.busy     <= 1'b1;
                            stat_q.crc_err  <= 1'b0;
                            stat_q.seek_err <= 1'b0;
                            verify_q        <= cmd_in.verify;
                            rate_q          <= cmd_in.rate;
                            if (!at_target) dir_q <= (target_q > track_q);
                        end else if (wr_en && addr == ADDR_TRACK) begin
                            track_q <= wdata;
                        end else if (wr_en && addr == ADDR_TARGET) begin
                            target_q <= wdata;
                        end
                    end
                    SQ_STEP: begin
                        if (at_target) begin
                            if (verify_q) begin
                                state_q <= SQ_VERIFY;
                            end else begin
                                state_q     <= SQ_IDLE;
                                stat_q.busy <= 1'b0;
                                irq_q       <= 1'b1;
                            end
                        end else if (step_due) begin
                            step_q  <= 1'b1;
                            track_q <= dir_q ? track_q + 1'b1 : track_q - 1'b1;
                        end
                    end
                    SQ_VERIFY: begin
                        if (vf_pass || vf_crc || vf_timeout) begin
                            state_q         <= SQ_IDLE;
                            stat_q.busy     <= 1'b0;
                            stat_q.crc_err  <= vf_crc;
                            stat_q.seek_err <= vf_timeout;
                            irq_q           <= 1'b1;
                        end
                    end
                    default: state_q <= SQ_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_CMD:    rdata = pack_status(stat_q);
            ADDR_TRACK:  rdata = track_q;
            ADDR_TARGET: rdata = target_q;
            default:     rdata = 8'h00;
        endcase
    end

    assign step_o     = step_q;
    assign step_dir_o = dir_q;
    assign irq_o      = irq_q;
endmodule

// File: rtl/seek_sequencer_chk.sv
module seek_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       irq,
    input logic       stat_rd,
    input logic       step,
    input logic       dir,
    input logic [7:0] track
);
    // R8
    busy_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    // R4
    step_width_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

    // R2
    step_track_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ((dir && track == $past(track) + 8'd1) ||
                  (!dir && track == $past(track) - 8'd1)));

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(dir));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_rd) |=> irq);

    // R11
    track_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !step) |-> $stable(track));

    // R10
    step_busy_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> busy);
endmodule

bind seek_sequencer seek_sequencer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_q),
    .irq     (irq_q),
    .stat_rd (stat_rd),
    .step    (step_q),
    .dir     (dir_q),
    .track   (track_q)
);

// File: tb/seek_sequencer_tb.sv
module seek_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NV         = 7;
    // start track, target, command, expected pulses, expected dir (2 = none)
    localparam int VEC [NV][5] = '{
        '{0,   5,   'h10, 5,   1},
        '{10,  7,   'h11, 3,   0},
        '{2,   6,   'h12, 4,   1},
        '{9,   8,   'h13, 1,   0},
        '{4,   4,   'h10, 0,   2},
        '{250, 255, 'h10, 5,   1},
        '{200, 0,   'h10, 200, 0}
    };

    logic clk = 0, rst = 1, tick_1k = 0, wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic index_pulse = 0, id_valid = 0, id_crc_ok = 0;
    logic [7:0] id_track = 0;
    logic step_o, step_dir_o, irq_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int pulse_cnt = 0, ticks_since = 0, rate_bad = 0, dir_bad = 0;
    int mon_rate = 6, mon_dir = 2;
    bit done = 0;

    seek_sequencer u_dut (
        .clk(clk), .rst(rst), .tick_1k(tick_1k), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .index_pulse(index_pulse),
        .id_valid(id_valid), .id_track(id_track), .id_crc_ok(id_crc_ok),
        .step_o(step_o), .step_dir_o(step_dir_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick source and step monitor
    always @(negedge clk) begin
        if (step_o) begin
            if (pulse_cnt > 0 && ticks_since != mon_rate) rate_bad++;
            if (mon_dir < 2 && int'(step_dir_o) != mon_dir) dir_bad++;
            ticks_since = 0;
            pulse_cnt++;
        end
        if (tick_1k) ticks_since++;
        cyc++;
        tick_1k = (cyc % TICK_DIV == 0);
    end

    function automatic int rate_of(input int cmd);
        case (cmd & 3)
            0: return 6;
            1: return 12;
            2: return 20;
            default: return 30;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic rd_stat();
        @(negedge clk);
        addr = 0; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wait_irq(output int seen);
        seen = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (irq_o) begin seen = 1; break; end
        end
    endtask

    task automatic wait_pulses(input int n);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (pulse_cnt >= n) break;
        end
    endtask

    task automatic send_id(input int trk, input bit ok);
        @(negedge clk);
        id_valid = 1; id_track = trk[7:0]; id_crc_ok = ok;
        @(negedge clk);
        id_valid = 0;
    endtask

    task automatic send_index();
        @(negedge clk);
        index_pulse = 1;
        @(negedge clk);
        index_pulse = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, seen;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        peek(0, v); chk("R12 status", v, 0);
        peek(1, v); chk("R12 track", v, 0);
        peek(2, v); chk("R12 target", v, 0);
        chk("R12 irq", int'(irq_o), 0);
        chk("R12 step", int'(step_o), 0);
        // R11 readback while idle
        wr(1, 'h33); peek(1, v); chk("R11 track readback", v, 'h33);
        wr(2, 'h5A); peek(2, v); chk("R11 target readback", v, 'h5A);

        // table of seeks: R1 R2 R3 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(1, VEC[i][0]);
            wr(2, VEC[i][1]);
            pulse_cnt = 0; rate_bad = 0; dir_bad = 0;
            mon_rate = rate_of(VEC[i][2]);
            mon_dir = VEC[i][4];
            wr(0, VEC[i][2]);
            peek(0, v); chk("R8 busy after accept", v & 1, 1);
            wait_irq(seen);
            chk("R8 irq at completion", seen, 1);
            @(negedge clk);
            peek(0, v); chk("R8 status after completion", v, 0);
            chk("R2 pulse count", pulse_cnt, VEC[i][3]);
            peek(1, v); chk("R2 final track", v, VEC[i][1]);
            chk("R1 step spacing", rate_bad, 0);
            chk("R3 direction", dir_bad, 0);
            rd_stat();
            chk("R9 irq cleared by status read", int'(irq_o), 0);
        end

        // R5 verify: non-matching ID ignored, matching ID passes
        wr(1, 3); wr(2, 5);
        pulse_cnt = 0; mon_rate = 6; mon_dir = 1;
        wr(0, 'h14);
        wait_pulses(2);
        repeat (3) @(negedge clk);
        peek(0, v); chk("R5 busy in verify", v, 1);
        send_id(4, 1);
        repeat (2) @(negedge clk);
        chk("R5 mismatch ignored irq", int'(irq_o), 0);
        peek(0, v); chk("R5 mismatch ignored busy", v, 1);
        send_id(5, 1);
        chk("R5 match irq", int'(irq_o), 1);
        peek(0, v); chk("R5 match status", v, 'h00);
        rd_stat();

        // R6 bad CRC during verify
        wr(1, 5); wr(2, 5);
        wr(0, 'h14);
        repeat (3) @(negedge clk);
        send_id(9, 0);
        chk("R6 irq", int'(irq_o), 1);
        peek(0, v); chk("R6 status", v, 'h08);
        rd_stat();

        // R7 index timeout
        wr(0, 'h14);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) send_index();
        @(negedge clk);
        peek(0, v); chk("R7 busy after four index", v, 1);
        chk("R7 no irq after four index", int'(irq_o), 0);
        send_index();
        chk("R7 irq", int'(irq_o), 1);
        peek(0, v); chk("R7 status", v, 'h10);
        rd_stat();

        // R10 R11 writes while busy are ignored
        wr(1, 0); wr(2, 3);
        pulse_cnt = 0; rate_bad = 0; dir_bad = 0; mon_rate = 12; mon_dir = 1;
        wr(0, 'h11);
        wait_pulses(1);
        wr(2, 9);
        wr(1, 50);
        wr(0, 'h10);
        wait_irq(seen);
        chk("R10 completes", seen, 1);
        chk("R10 pulse count", pulse_cnt, 3);
        chk("R10 rate unchanged", rate_bad, 0);
        peek(1, v); chk("R11 track unchanged by busy write", v, 3);
        peek(2, v); chk("R11 target unchanged by busy write", v, 3);
        rd_stat();

        // R10 abort mid-seek
        wr(1, 0); wr(2, 20);
        pulse_cnt = 0; rate_bad = 0; mon_rate = 30; mon_dir = 1;
        wr(0, 'h13);
        wait_pulses(2);
        chk("R10 no irq before abort", int'(irq_o), 0);
        wr(0, 'hD0);
        chk("R10 abort irq", int'(irq_o), 1);
        peek(0, v); chk("R10 abort clears busy", v, 0);
        repeat (300) @(negedge clk);
        chk("R10 no pulses after abort", pulse_cnt, 2);
        peek(1, v); chk("R10 track frozen after abort", v, 2);
        rd_stat();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule